// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM of 32K words by 8 bits. The host raises a request together with an address, a direction flag and, for a write, a data byte, and holds it until a single-cycle acknowledge comes back. A read returns its byte with that acknowledge. On the memory side the block drives active-low chip select, write strobe and output enable, the address bus, and a split data bus: outgoing data, a driver enable for the board-level tristate buffer, and incoming data.

Every timing phase is a whole number of clock cycles. Each count is derived at elaboration from a nanosecond-class parameter (given in picoseconds) and the clock period. The derivation rounds up and never yields less than one cycle. Writes are controlled by the write strobe and always run with output enable high. Reads hold chip select and output enable low for the full access time and capture the byte on the last cycle. A turnaround counter keeps the data drivers off until the memory has had time to float its outputs after a read.

Top module: `asram_sequencer`

## Requirements
- R1: While reset is asserted, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_dq_oe is 0 and host_ack is 0.
- R2: sram_we_n is low only while sram_ce_n is low and sram_oe_n is high, and a completed write stores host_wdata at host_addr so a later read returns it.
- R3: The write strobe stays low for max(cyc(T_WP), cyc(T_DS)) cycles with data driven throughout, and the data drivers stay on for at least the cycle in which the write strobe rises.
- R4: Chip select stays low for at least cyc(T_WC) cycles during a write.
- R5: A read holds sram_ce_n and sram_oe_n low with sram_we_n high for max(cyc(T_RC), cyc(T_AA), cyc(T_ACE), cyc(T_DOE)) cycles and captures sram_dq_i on the last of them.
- R6: host_ack is high for exactly one cycle per access, host_rdata carries the read byte in that cycle, and all strobes are inactive with drivers off in that cycle.
- R7: sram_dq_oe is 1 only while sram_oe_n is 1 and sram_oe_n has been 1 for at least cyc(T_HZ) cycles; a write that follows a read waits until then.
- R8: sram_addr is stable while sram_ce_n stays low, it is set no later than the cycle in which sram_ce_n falls, and sram_dq_o is stable while sram_dq_oe stays 1.
- R9: A request is taken only in the idle state, and sram_ce_n is 1 while idle.
- R10: cyc(t) = max(1, ceil(t / CLK_PS)); from the cycle a request is taken to the acknowledge a read takes 1 + read cycles, and a write takes 1 + wait + pulse + recovery cycles, with recovery = max(1, cyc(T_WC) − pulse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, held until host_ack |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read byte, valid with host_ack |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_dq_o | output | DATA_W | Outgoing data to the bus buffer |
| sram_dq_oe | output | 1 | Enable for the outgoing data buffer |
| sram_dq_i | input | DATA_W | Incoming data from the memory |

## Verification
The assertions assume the host drops host_req in the cycle it sees host_ack and does not change the address, flag or data while a request is pending. They also assume the memory keeps driving sram_dq_i for up to cyc(T_HZ) cycles after its output enable is released. The bench meets the first assumption by raising and lowering the request only on falling clock edges inside a single task. It models the second with a memory that keeps holding the bus for that many cycles. That memory returns a poison byte until the access time has elapsed, so a short read fails. The bench sweeps every address of a narrowed configuration. It varies the idle gap between a read and the following write so that the turnaround wait is exercised across all its lengths.

// File: rtl/asq_pkg.sv
package asq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_W_TURN   = 3'd1,
        ST_W_PULSE  = 3'd2,
        ST_W_RECOV  = 3'd3,
        ST_R_ACCESS = 3'd4
    } asq_state_e;

    // Whole cycles covering a time in picoseconds, never below one.
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asq_phase_timer.sv
module asq_phase_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    AST_TMR_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R10

endmodule

// File: rtl/asq_bus_quiet.sv
module asq_bus_quiet #(
    parameter int unsigned HZ_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n_next,
    output logic quiet
);

    localparam int unsigned QW = $clog2(HZ_CYC + 1);
    localparam logic [QW-1:0] HZ_V = QW'(HZ_CYC);

    logic [QW-1:0] qcnt_d, qcnt_q;

    // Counts the cycles that output enable has been released, saturating.
    always_comb begin
        if (!oe_n_next) begin
            qcnt_d = '0;
        end else if (qcnt_q < HZ_V) begin
            qcnt_d = qcnt_q + 1'b1;
        end else begin
            qcnt_d = qcnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt_q <= HZ_V;
        end else begin
            qcnt_q <= qcnt_d;
        end
    end

    assign quiet = (qcnt_q >= HZ_V);

    AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_next |=> !quiet); // R7

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
    import asq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned T_WC_PS   = 12000,
    parameter int unsigned T_WP_PS   = 8000,
    parameter int unsigned T_DS_PS   = 7000,
    parameter int unsigned T_RC_PS   = 12000,
    parameter int unsigned T_AA_PS   = 12000,
    parameter int unsigned T_ACE_PS  = 12000,
    parameter int unsigned T_DOE_PS  = 5000,
    parameter int unsigned T_HZ_PS   = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int unsigned PULSE_CYC = umax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_DS_PS, CLK_PS));
    localparam int unsigned WC_CYC    = ps_to_cyc(T_WC_PS, CLK_PS);
    localparam int unsigned RECOV_CYC = (WC_CYC > PULSE_CYC) ? (WC_CYC - PULSE_CYC) : 1;
    localparam int unsigned RD_CYC    = umax(umax(ps_to_cyc(T_RC_PS, CLK_PS), ps_to_cyc(T_AA_PS, CLK_PS)),
                                             umax(ps_to_cyc(T_ACE_PS, CLK_PS), ps_to_cyc(T_DOE_PS, CLK_PS)));
    localparam int unsigned HZ_CYC    = ps_to_cyc(T_HZ_PS, CLK_PS);
    localparam int unsigned CNT_MAX   = umax(PULSE_CYC, umax(RECOV_CYC, RD_CYC));
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);

    typedef struct packed {
        asq_state_e        state;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              ack;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state: ST_IDLE, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0,
        ack: 1'b0, addr: '0, wdata: '0, rdata: '0
    };

    ctl_t             r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             bus_quiet;

    asq_phase_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asq_bus_quiet #(
        .HZ_CYC (HZ_CYC)
    ) i_quiet (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_n_next (r_d.oe_n),
        .quiet     (bus_quiet)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                r_d.ce_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.dq_oe = 1'b0;
                if (host_req) begin
                    r_d.addr = host_addr;
                    r_d.ce_n = 1'b0;
                    if (host_we) begin
                        r_d.wdata = host_wdata;
                        if (bus_quiet) begin
                            r_d.state = ST_W_PULSE;
                            r_d.we_n  = 1'b0;
                            r_d.dq_oe = 1'b1;
                            tmr_load  = 1'b1;
                            tmr_val   = PULSE_LD;
                        end else begin
                            r_d.state = ST_W_TURN;
                        end
                    end else begin
                        r_d.state = ST_R_ACCESS;
                        r_d.oe_n  = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = RD_LD;
                    end
                end
            end

            ST_W_TURN: begin
                if (bus_quiet) begin
                    r_d.state = ST_W_PULSE;
                    r_d.we_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = PULSE_LD;
                end
            end

            ST_W_PULSE: begin
                if (tmr_done) begin
                    r_d.state = ST_W_RECOV;
                    r_d.we_n  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = RECOV_LD;
                end
            end

            ST_W_RECOV: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.ce_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.ack   = 1'b1;
                end
            end

            ST_R_ACCESS: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.rdata = sram_dq_i;
                    r_d.oe_n  = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.ack   = 1'b1;
                end
            end

            default: begin
                r_d = CTL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ack   = r_q.ack;
    assign host_rdata = r_q.rdata;
    assign sram_ce_n  = r_q.ce_n;
    assign sram_we_n  = r_q.we_n;
    assign sram_oe_n  = r_q.oe_n;
    assign sram_addr  = r_q.addr;
    assign sram_dq_o  = r_q.wdata;
    assign sram_dq_oe = r_q.dq_oe;

    AST_DRV_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R7
    AST_DRV_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> $past(bus_quiet)); // R7
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n)); // R2
    AST_WE_RISE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R8
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o)); // R8
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R6
    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe)); // R6
    AST_IDLE_WAITS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !host_req) |=> (r_q.state == ST_IDLE && sram_ce_n)); // R9

endmodule

// File: tb/test_asram_sequencer.sv
module test_asram_sequencer;

    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int NWORDS = 1 << AW;
    localparam int CLK_PS = 4000;

    function automatic int cyc(input int t_ps);
        int c;
        c = (t_ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int PULSE = (cyc(8000) > cyc(7000)) ? cyc(8000) : cyc(7000);
    localparam int WC    = cyc(12000);
    localparam int RECOV = (WC > PULSE) ? WC - PULSE : 1;
    localparam int RD    = cyc(12000);
    localparam int HZ    = cyc(6000);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_req;
    logic          host_we;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic          sram_ce_n, sram_we_n, sram_oe_n;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_o;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_dq_i;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #10 clk = ~clk;

    asram_sequencer #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .CLK_PS (CLK_PS)
    ) i_asram_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .sram_ce_n  (sram_ce_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .sram_addr  (sram_addr),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe),
        .sram_dq_i  (sram_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Memory model, sampled on falling edges.
    logic [DW-1:0] model_mem [NWORDS];
    int            rd_age = 0;
    int            hold   = 0;
    int            wlow   = 0;
    int            celow  = 0;
    bit            prev_we_n = 1'b1;
    bit            prev_ce_n = 1'b1;
    bit            wr_in_cycle = 1'b0;
    logic [AW-1:0] ce_addr = '0;
    logic [DW-1:0] wdat = '0;

    initial sram_dq_i = 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            bit en_rd;
            en_rd = !sram_ce_n && !sram_oe_n && sram_we_n;
            if (sram_dq_oe) begin
                chk(!(en_rd || hold > 0), "R7 bus conflict", hold, 0);
            end
            if (!sram_we_n) begin
                chk(!sram_ce_n && sram_oe_n && sram_dq_oe, "R2 strobe state",
                    {sram_ce_n, sram_oe_n, sram_dq_oe}, 3'b011);
                if (wlow > 0) begin
                    chk(sram_dq_o == wdat, "R8 data held", sram_dq_o, wdat);
                end
                wdat = sram_dq_o;
                wlow++;
                wr_in_cycle = 1'b1;
            end
            if (sram_we_n && !prev_we_n) begin
                chk(wlow >= PULSE, "R3 pulse width", wlow, PULSE);
                chk(sram_dq_oe && sram_dq_o == wdat, "R3 data at strobe rise", sram_dq_o, wdat);
                if (!sram_ce_n) begin
                    model_mem[sram_addr] = sram_dq_o;
                end
                wlow = 0;
            end
            if (!sram_ce_n) begin
                if (!prev_ce_n) begin
                    chk(sram_addr == ce_addr, "R8 address held", sram_addr, ce_addr);
                end
                ce_addr = sram_addr;
                celow++;
            end else if (!prev_ce_n) begin
                if (wr_in_cycle) begin
                    chk(celow >= WC, "R4 select span", celow, WC);
                end else begin
                    chk(celow >= RD, "R5 select span", celow, RD);
                end
                celow = 0;
                wr_in_cycle = 1'b0;
            end
            if (en_rd) begin
                rd_age++;
                hold = HZ;
                sram_dq_i = (rd_age >= RD) ? model_mem[sram_addr] : 8'hEE;
            end else begin
                rd_age = 0;
                if (hold > 0) hold--;
                sram_dq_i = 8'hEE;
            end
            prev_we_n = sram_we_n;
            prev_ce_n = sram_ce_n;
        end
    end

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 7 + 3) ^ (a >> 3));
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'(~((a * 13 + 91) & 255));
    endfunction

    bit last_was_read = 1'b0;

    task automatic xfer(input bit we, input int a, input logic [DW-1:0] d,
                        input int gap, input logic [DW-1:0] exp_rd);
        int lat;
        int turn;
        int exp_lat;
        for (int g = 0; g < gap; g++) begin
            chk(sram_ce_n == 1'b1, "R9 idle select", sram_ce_n, 1);
            @(negedge clk);
        end
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = AW'(a);
        host_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ack && lat < 100);
        host_req = 1'b0;
        chk(host_ack, "R6 ack seen", host_ack, 1);
        if (we) begin
            turn    = last_was_read ? imax(0, HZ - (1 + gap)) : 0;
            exp_lat = 1 + turn + PULSE + RECOV;
            chk(lat == exp_lat, "R10 write latency", lat, exp_lat);
        end else begin
            exp_lat = 1 + RD;
            chk(lat == exp_lat, "R10 read latency", lat, exp_lat);
            chk(host_rdata == exp_rd, "R5 read data", host_rdata, exp_rd);
        end
        last_was_read = !we;
    endtask

    initial begin
        rst_n      = 1'b0;
        host_req   = 1'b0;
        host_we    = 1'b0;
        host_addr  = '0;
        host_wdata = '0;
        repeat (3) @(negedge clk);
        chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack} == 5'b11100,
            "R1 reset outputs", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sram_ce_n == 1'b1, "R9 idle after reset", sram_ce_n, 1);

        // Fill every word (R2, R3, R4).
        for (int a = 0; a < NWORDS; a++) begin
            xfer(1'b1, a, pat_a(a), a % 3, '0);
        end
        // Read, overwrite right after the read with varying gaps (R7), read back.
        for (int a = 0; a < NWORDS; a++) begin
            xfer(1'b0, a, '0, a % 2, pat_a(a));
            xfer(1'b1, a, pat_b(a), a % 3, '0);
            xfer(1'b0, a, '0, 0, pat_b(a));
        end
        // Back-to-back reads with no gap (R5, R6).
        for (int a = NWORDS - 1; a >= NWORDS - 8; a--) begin
            xfer(1'b0, a, '0, 0, pat_b(a));
        end
        @(negedge clk);
        chk(host_ack == 1'b0, "R6 ack single cycle", host_ack, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule